// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-line general-purpose I/O port placed behind a simple byte-wide register bus. It holds a direction register and an output latch. It drives pad outputs and their output enables, and it brings the pad inputs into the clock domain through a two-flop synchronizer. The synchronized lines are also exposed, so that a separate interrupt-detection block can use them.

Data-register accesses use address bits [9:2] as a per-line lane mask. Software can therefore set, clear or sample any subset of pins in one access, with no read-modify-write sequence. A write to the output latch only lands on lines that are already outputs. When software turns a line into an output, it must write that line's value again. Four read-only bytes near the top of the 4 KB window return a fixed identification word, least significant byte first.

Every bus access is a single-cycle strobe. Read data is registered: it appears one edge after the request and is held until the next read.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every line is an input: the direction register reads 0x00, the output latch is 0, `padOe` is 0x00 and `padOut` is 0x00.
- R2: The direction register is at offset 0x400 and can be read and written. A bit value of 1 makes line n an output, and `padOe[n]` follows that bit one edge after the write.
- R3: A write anywhere in the data window (offsets 0x000 to 0x3FC) updates latch bit n from write-data bit n only when address bit n+2 is set. `padOut` always shows the latch.
- R4: A data write does not change the latch bit of a line that is an input. Turning a line into an output afterwards does not change its latch bit either, so the value has to be written again.
- R5: A data-window read returns the line value on each bit whose address-mask bit n+2 is set, and 0 on every other bit. The line value is the latch bit for an output line and the synchronized pad input for an input line.
- R6: A change on `padIn` shows up on `lineSync` after two rising edges. A data read whose request is sampled on the third edge after the change, or later, returns the new value.
- R7: Reads at offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC return 0x61, 0x10, 0x04 and 0x00, which is the word 0x00041061 least significant byte first. Writes to these offsets have no effect.
- R8: Reads of any other offset, or of any offset whose bits [1:0] are not 00, return 0x00. Writes to such offsets leave the direction register and the latch unchanged.
- R9: `busRdata` is loaded on the edge that samples a read request and keeps its value on every edge without one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access strobe for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset within the 4 KB window |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| padIn | input | 8 | Asynchronous pad inputs |
| padOut | output | 8 | Output latch to the pads |
| padOe | output | 8 | Pad output enables (1 = drive) |
| lineSync | output | 8 | Synchronized pad inputs |

## Verification
Two things can meet in the same cycle: an input pin changes while it is being sampled through the synchronizer, and a masked data read of that pin. The bench changes `padIn` on the same half-cycle in which it issues back-to-back reads of the affected lanes. The scoreboard expects the old value for reads sampled on the first and second edges after the change, and the new value from the third edge on, and `lineSync` is checked between those reads. A second overlap is the masked data write, which is gated by direction. Writes that cover input lanes are issued both before and after the direction changes, and `padOut` must show the latch changing only on lanes that are masked in and configured as outputs.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_DATA = 2'd1,
    RD_DIR  = 2'd2,
    RD_ID   = 2'd3
  } rdSrc_e;

  // Strobes from the decoder to the datapath, valid for one cycle
  typedef struct packed {
    logic       dirWe;
    logic       dataWe;
    logic       rdEn;
    rdSrc_e     rdSrc;
    logic [1:0] idIdx;
  } ctrlStrb_t;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] asyncIn,
  output logic [NUM_LINES-1:0] syncOut
);

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= asyncIn[n];
        stage2 <= stage1;
      end
    end
    assign syncOut[n] = stage2;
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_LINES  = 8,
  parameter int DIR_OFFSET = 'h400,
  parameter int ID_BASE    = 'hFE0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  output ctrlStrb_t            strb,
  output logic [NUM_LINES-1:0] laneMask
);

  localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFFSET);
  localparam logic [ADDR_W-1:0] ID_A   = ADDR_W'(ID_BASE);
  localparam int                LANE_LSB = 2;

  logic aligned;
  logic inData;
  logic inDir;
  logic inId;

  always_comb begin
    aligned = (busAddr[1:0] == 2'b00);
    inData  = aligned && (busAddr < DIR_A);
    inDir   = aligned && (busAddr[ADDR_W-1:2] == DIR_A[ADDR_W-1:2]);
    inId    = aligned && (busAddr[ADDR_W-1:4] == ID_A[ADDR_W-1:4]);
    laneMask = busAddr[LANE_LSB +: NUM_LINES];

    strb        = '0;
    strb.dirWe  = busSel && busWrite && inDir;
    strb.dataWe = busSel && busWrite && inData;
    strb.rdEn   = busSel && !busWrite;
    strb.idIdx  = busAddr[3:2];
    if (inData)     strb.rdSrc = RD_DATA;
    else if (inDir) strb.rdSrc = RD_DIR;
    else if (inId)  strb.rdSrc = RD_ID;
    else            strb.rdSrc = RD_NONE;
  end

  // R7: identification offsets never raise a write strobe
  p_id_readonly_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && inId) |-> !(strb.dirWe || strb.dataWe));

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int          NUM_LINES = 8,
  parameter logic [31:0] ID_VALUE  = 32'h0004_1061
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  logic [NUM_LINES-1:0] laneMask,
  input  logic [NUM_LINES-1:0] busWdata,
  input  logic [NUM_LINES-1:0] padIn,
  output logic [NUM_LINES-1:0] busRdata,
  output logic [NUM_LINES-1:0] padOut,
  output logic [NUM_LINES-1:0] padOe,
  output logic [NUM_LINES-1:0] lineSync
);

  logic [NUM_LINES-1:0] dirReg;
  logic [NUM_LINES-1:0] outLatch;
  logic [NUM_LINES-1:0] wrMask;
  logic [NUM_LINES-1:0] lineVal;
  logic [NUM_LINES-1:0] rdNext;
  logic [7:0]           idByte;

  gpio_port_sync #(.NUM_LINES(NUM_LINES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (padIn),
    .syncOut (lineSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           dirReg <= '0;
    else if (strb.dirWe) dirReg <= busWdata;
  end

  // Only lanes that are addressed and already outputs take the write
  assign wrMask = laneMask & dirReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outLatch <= '0;
    else if (strb.dataWe) outLatch <= (outLatch & ~wrMask) | (busWdata & wrMask);
  end

  assign padOut  = outLatch;
  assign padOe   = dirReg;
  assign lineVal = (outLatch & dirReg) | (lineSync & ~dirReg);
  assign idByte  = ID_VALUE[{strb.idIdx, 3'b000} +: 8];

  always_comb begin
    case (strb.rdSrc)
      RD_DATA: rdNext = lineVal & laneMask;
      RD_DIR:  rdNext = dirReg;
      RD_ID:   rdNext = NUM_LINES'(idByte);
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busRdata <= '0;
    else if (strb.rdEn) busRdata <= rdNext;
  end

  // Cycles since reset, saturating at 2, used to qualify the synchronizer check
  logic [1:0] syncAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              syncAge <= '0;
    else if (syncAge != 2'd2) syncAge <= syncAge + 2'd1;
  end

  // R6: two-edge synchronizer delay
  p_sync_delay_r6: assert property (@(posedge clk) disable iff (!rstN)
    (syncAge == 2'd2) |-> (lineSync == $past(padIn, 2)));

  // R2: direction register takes the written byte
  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.dirWe |=> (padOe == $past(busWdata)));

  // R4: latch bits change only on addressed output lanes of a data write
  p_latch_guard_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((padOut ^ $past(padOut)) &
               ~($past(wrMask) & {NUM_LINES{$past(strb.dataWe)}})) == '0));

  // R8: unmapped reads return zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSrc == RD_NONE) |=> (busRdata == '0));

  // R9: read data holds without a read request
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(busRdata));

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_port_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          NUM_LINES  = 8,
  parameter int          DIR_OFFSET = 'h400,
  parameter int          ID_BASE    = 'hFE0,
  parameter logic [31:0] ID_VALUE   = 32'h0004_1061
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [NUM_LINES-1:0] busWdata,
  output logic [NUM_LINES-1:0] busRdata,
  input  logic [NUM_LINES-1:0] padIn,
  output logic [NUM_LINES-1:0] padOut,
  output logic [NUM_LINES-1:0] padOe,
  output logic [NUM_LINES-1:0] lineSync
);

  ctrlStrb_t            strb;
  logic [NUM_LINES-1:0] laneMask;

  gpio_port_ctrl #(
    .ADDR_W     (ADDR_W),
    .NUM_LINES  (NUM_LINES),
    .DIR_OFFSET (DIR_OFFSET),
    .ID_BASE    (ID_BASE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb),
    .laneMask (laneMask)
  );

  gpio_port_dp #(
    .NUM_LINES (NUM_LINES),
    .ID_VALUE  (ID_VALUE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .laneMask (laneMask),
    .busWdata (busWdata),
    .padIn    (padIn),
    .busRdata (busRdata),
    .padOut   (padOut),
    .padOe    (padOe),
    .lineSync (lineSync)
  );

endmodule

// File: tb/sim_gpio_mask_port.sv
`timescale 1ns/1ps
module sim_gpio_mask_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [7:0]  padIn = '0;
  logic [7:0]  padOut;
  logic [7:0]  padOe;
  logic [7:0]  lineSync;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  gpio_mask_port u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .lineSync(lineSync)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Driver tasks: called at a falling edge, return at the next falling edge
  task automatic busWr(input logic [11:0] a, input logic [7:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  // Monitor: a read sampled on a rising edge is compared on the next falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (busSel && !busWrite) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard: unexpected read result 0x%02h expected none", busRdata);
        end else begin
          chk(busRdata, expQ.pop_front(), tagQ.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(padOe,  8'h00, "R1 padOe after reset");
    chk(padOut, 8'h00, "R1 padOut after reset");
    busRd(12'h400, 8'h00, "R1 direction after reset");
    busRd(12'h3FC, 8'h00, "R1 data after reset");

    // R2 direction register
    busWr(12'h400, 8'h0F);
    chk(padOe, 8'h0F, "R2 padOe follows direction");
    busRd(12'h400, 8'h0F, "R2 direction readback");

    // R3 / R4 full-mask write: only output lanes 0..3 take it
    busWr(12'h3FC, 8'hFF);
    chk(padOut, 8'h0F, "R3 R4 full mask write on outputs only");
    busWr(12'h008, 8'h00);               // lane 1 only
    chk(padOut, 8'h0D, "R3 single lane clear");
    busWr(12'h014, 8'h00);               // lanes 0 and 2
    chk(padOut, 8'h08, "R3 two lane clear");
    busWr(12'h004, 8'hFE);               // lane 0 mask, data bit0 = 0
    chk(padOut, 8'h08, "R3 masked write uses own data bit");

    // R4 write to an input lane, then make it an output
    busWr(12'h080, 8'h20);               // lane 5 is an input
    chk(padOut, 8'h08, "R4 write to input ignored");
    busWr(12'h400, 8'h2F);
    chk(padOut, 8'h08, "R4 direction change keeps latch");
    busWr(12'h080, 8'h20);
    chk(padOut, 8'h28, "R4 rewrite after direction change");

    // R5 masked reads mixing outputs and inputs
    padIn = 8'hC0;
    repeat (4) @(negedge clk);
    busRd(12'h3FC, 8'hE8, "R5 full mask mixed read");
    busRd(12'h300, 8'hC0, "R5 lanes 6 and 7 inputs");
    busRd(12'h020, 8'h08, "R5 lane 3 output");
    busRd(12'h040, 8'h00, "R5 lane 4 input low");
    busRd(12'h000, 8'h00, "R5 empty mask");

    // R6 input change meets a read in the same cycle
    padIn = 8'h40;
    busRd(12'h300, 8'hC0, "R6 read on first edge sees old");
    chk(lineSync, 8'hC0, "R6 lineSync after one edge");
    busRd(12'h300, 8'hC0, "R6 read on second edge sees old");
    chk(lineSync, 8'h40, "R6 lineSync after two edges");
    busRd(12'h300, 8'h40, "R6 read on third edge sees new");

    // R7 identification bytes
    busRd(12'hFE0, 8'h61, "R7 id byte 0");
    busRd(12'hFE4, 8'h10, "R7 id byte 1");
    busRd(12'hFE8, 8'h04, "R7 id byte 2");
    busRd(12'hFEC, 8'h00, "R7 id byte 3");
    busWr(12'hFE0, 8'hFF);
    busRd(12'hFE0, 8'h61, "R7 id write ignored");

    // R8 unmapped offsets
    busRd(12'h404, 8'h00, "R8 unmapped read 0x404");
    busRd(12'h800, 8'h00, "R8 unmapped read 0x800");
    busRd(12'h401, 8'h00, "R8 misaligned read");
    busWr(12'h404, 8'hFF);
    busWr(12'hFF0, 8'hFF);
    busWr(12'h402, 8'hFF);
    busWr(12'h3FD, 8'h00);
    busRd(12'h400, 8'h2F, "R8 direction unchanged");
    chk(padOut, 8'h28, "R8 latch unchanged");

    // R9 read data holds while idle
    repeat (5) @(negedge clk);
    chk(busRdata, 8'h2F, "R9 read data held");
    busWr(12'h400, 8'h00);
    chk(busRdata, 8'h2F, "R9 held across write");
    chk(padOe, 8'h00, "R2 all lines back to input");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule